// File: doc/BRIEF.md
# Graphics Layer Pixel Expander

This block sits in the per-layer graphics path, between the pixel fetch and the scaler or blender. Each accepted input word holds one raw graphics pixel in one of several packed layouts, chosen per pixel by a format code. The block turns that word into a uniform 32-bit ARGB value with 8 bits per channel. It then works out one final 8-bit opacity for the pixel from three settings: a per-layer global alpha, the pixel's own alpha, and two transparency rules. The first rule is an RGB colour key. The second is a separate one-bit stencil plane.

Indexed (bitmap) pixels are looked up in a 256-entry table of ARGB colours held inside the block. Software-side logic loads the table through a simple write port. Input and output both use a valid/ready handshake. A single output register gives one cycle of latency and accepts one pixel per cycle when the consumer is not stalling.

Top module: `gfx_pixel_expander`

## Requirements
- R1: After reset, out_valid is 0 and every colour table entry reads as 0x00000000.
- R2: Format code 0 passes the 32-bit word through as A[31:24] R[23:16] G[15:8] B[7:0]. Format code 1 takes RGB from bits 23:0, ignores bits 31:24, and gives pixel alpha 0xFF.
- R3: Sixteen-bit formats use bits 15:0, with narrow fields widened by copying their top bits below them. Code 2 has A=bit15 (0 gives 0x00, 1 gives 0xFF), R=14:10, G=9:5, B=4:0. Code 3 has R=15:11, G=10:5, B=4:0 and alpha 0xFF. Code 4 has A=15:12, R=11:8, G=7:4, B=3:0.
- R4: Codes 5, 6, 7 and 8 are indexed pixels using bit 0, bits 1:0, bits 3:0 and bits 7:0 of the word. The index selects a table entry, and the output RGB is that entry's bits 23:0.
- R5: For indexed pixels, pixel alpha is the entry's bits 31:24 when clut_alpha_sel is 1, and 0xFF when it is 0. For direct formats, pixel alpha comes from the format's own field.
- R6: out_argb[31:24] carries the pixel alpha. When the pixel is neither keyed nor masked, out_alpha depends on alpha_mode. Mode 0 gives global_alpha. Mode 1 gives the pixel alpha. Modes 2 and 3 give round(pixel_alpha*global_alpha/255).
- R7: When key_en is 1 and the expanded RGB equals key_rgb, out_alpha is 0x00. Alpha plays no part in the match, and out_argb still carries the expanded colour.
- R8: When stencil_en is 1 and in_stencil is 0, out_alpha is 0x00. When stencil_en is 0, in_stencil has no effect.
- R9: in_ready is 1 exactly when the output register is empty or is being read. A pixel accepted on one edge appears on the outputs after that edge. The outputs hold steady while out_valid=1 and out_ready=0.
- R10: A table write with clut_we=1 takes effect at the clock edge. A pixel accepted on that same edge still sees the previous entry, and later pixels see the new one.
- R11: Format codes 9 to 15 are decoded exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_pixel | input | 32 | Raw pixel word |
| in_fmt | input | 4 | Format code of the pixel |
| in_stencil | input | 1 | Stencil plane bit (1 = visible) |
| stencil_en | input | 1 | Enable stencil masking |
| global_alpha | input | 8 | Per-layer alpha |
| alpha_mode | input | 2 | Final alpha selection |
| clut_alpha_sel | input | 1 | Indexed pixels take alpha from table entry |
| key_en | input | 1 | Enable colour key |
| key_rgb | input | 24 | Key colour, RGB888 |
| clut_we | input | 1 | Table write strobe |
| clut_waddr | input | 8 | Table write address |
| clut_wdata | input | 32 | Table write data, ARGB8888 |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output |
| out_argb | output | 32 | Expanded ARGB8888 pixel |
| out_alpha | output | 8 | Final opacity |

## Verification
The assertions assume that in_valid, in_pixel, in_fmt, in_stencil and the settings are meaningful only on the edge where the handshake completes. They also assume the consumer may hold out_ready low for any number of cycles. The bench changes inputs only on falling edges. Most of the time it keeps out_ready high, and it drops out_ready in one directed stall so that the hold and backpressure properties are exercised. The settings are randomised per pixel, and the key colour is sometimes set to the pixel's own expanded colour so that key hits actually occur.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PIX_W = 32;
  localparam int CH_W  = 8;

  typedef enum logic [3:0] {
    FMT_ARGB8888 = 4'd0,
    FMT_RGB888   = 4'd1,
    FMT_ARGB1555 = 4'd2,
    FMT_RGB565   = 4'd3,
    FMT_ARGB4444 = 4'd4,
    FMT_IDX1     = 4'd5,
    FMT_IDX2     = 4'd6,
    FMT_IDX4     = 4'd7,
    FMT_IDX8     = 4'd8
  } gpx_fmt_e;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // round(a*b/255) using the add-and-fold trick, exact for 8-bit operands
  function automatic logic [7:0] alpha_scale(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] t;
    logic [15:0] u;
    t = 16'(x) * 16'(y) + 16'd128;
    u = t + (t >> 8);
    return u[15:8];
  endfunction
endpackage

// File: rtl/gpx_unpack.sv
module gpx_unpack
  import gpx_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic [3:0]       fmt,
  output argb_t            direct,
  output logic             use_clut,
  output logic [7:0]       idx
);
  always_comb begin
    direct   = pix;
    use_clut = 1'b0;
    idx      = 8'd0;
    case (fmt)
      FMT_RGB888:   direct = {8'hFF, pix[23:0]};
      FMT_ARGB1555: begin
        direct.a = {8{pix[15]}};
        direct.r = widen5(pix[14:10]);
        direct.g = widen5(pix[9:5]);
        direct.b = widen5(pix[4:0]);
      end
      FMT_RGB565: begin
        direct.a = 8'hFF;
        direct.r = widen5(pix[15:11]);
        direct.g = widen6(pix[10:5]);
        direct.b = widen5(pix[4:0]);
      end
      FMT_ARGB4444: begin
        direct.a = widen4(pix[15:12]);
        direct.r = widen4(pix[11:8]);
        direct.g = widen4(pix[7:4]);
        direct.b = widen4(pix[3:0]);
      end
      FMT_IDX1: begin use_clut = 1'b1; idx = {7'd0, pix[0]};   end
      FMT_IDX2: begin use_clut = 1'b1; idx = {6'd0, pix[1:0]}; end
      FMT_IDX4: begin use_clut = 1'b1; idx = {4'd0, pix[3:0]}; end
      FMT_IDX8: begin use_clut = 1'b1; idx = pix[7:0];         end
      default:  direct = pix;
    endcase
  end
endmodule

// File: rtl/gpx_clut.sv
module gpx_clut #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/gpx_alpha.sv
module gpx_alpha
  import gpx_pkg::*;
(
  input  logic [7:0] pix_alpha,
  input  logic [7:0] global_alpha,
  input  logic [1:0] mode,
  input  logic       keyed,
  input  logic       masked,
  output logic [7:0] final_alpha
);
  always_comb begin
    if (keyed || masked)   final_alpha = 8'h00;
    else if (mode == 2'd0) final_alpha = global_alpha;
    else if (mode == 2'd1) final_alpha = pix_alpha;
    else                   final_alpha = alpha_scale(pix_alpha, global_alpha);
  end
endmodule

// File: rtl/gfx_pixel_expander.sv
module gfx_pixel_expander
  import gpx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_pixel,
  input  logic [3:0]       in_fmt,
  input  logic             in_stencil,
  input  logic             stencil_en,
  input  logic [7:0]       global_alpha,
  input  logic [1:0]       alpha_mode,
  input  logic             clut_alpha_sel,
  input  logic             key_en,
  input  logic [23:0]      key_rgb,
  input  logic             clut_we,
  input  logic [IDX_W-1:0] clut_waddr,
  input  logic [31:0]      clut_wdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_argb,
  output logic [7:0]       out_alpha
);
  argb_t             direct;
  argb_t             expanded;
  logic              use_clut;
  logic [7:0]        idx8;
  logic [31:0]       clut_rd;
  logic [7:0]        alpha_final;
  logic              fire;
  logic              key_hit;
  logic              masked;

  gpx_unpack u_unpack (
    .pix      (in_pixel),
    .fmt      (in_fmt),
    .direct   (direct),
    .use_clut (use_clut),
    .idx      (idx8)
  );

  gpx_clut #(.IDX_W(IDX_W), .DATA_W(32)) u_clut (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (clut_we),
    .waddr (clut_waddr),
    .wdata (clut_wdata),
    .raddr (idx8[IDX_W-1:0]),
    .rdata (clut_rd)
  );

  always_comb begin
    if (use_clut) begin
      expanded   = clut_rd;
      expanded.a = clut_alpha_sel ? clut_rd[31:24] : 8'hFF;
    end else begin
      expanded = direct;
    end
  end

  assign key_hit = key_en && ({expanded.r, expanded.g, expanded.b} == key_rgb);
  assign masked  = stencil_en && !in_stencil;

  gpx_alpha u_alpha (
    .pix_alpha    (expanded.a),
    .global_alpha (global_alpha),
    .mode         (alpha_mode),
    .keyed        (key_hit),
    .masked       (masked),
    .final_alpha  (alpha_final)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_argb  <= '0;
      out_alpha <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_argb  <= expanded;
        out_alpha <= alpha_final;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic [3:0]  in_fmt,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_argb,
  input logic [7:0]  out_alpha,
  input logic        fire,
  input logic        key_hit,
  input logic        masked
);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_argb) && $stable(out_alpha));

  a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r9_issue: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r8_stencil_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fire && masked |=> out_alpha == 8'h00);

  a_r7_key_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fire && key_hit |=> out_alpha == 8'h00);

  a_r2_rgb888_opaque: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_fmt == 4'd1 |=> out_argb[31:24] == 8'hFF);

  a_r3_1555_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_fmt == 4'd2 |=> (out_argb[31:24] == 8'h00 || out_argb[31:24] == 8'hFF));
endmodule

bind gfx_pixel_expander gpx_checker u_gpx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_fmt    (in_fmt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_argb  (out_argb),
  .out_alpha (out_alpha),
  .fire      (fire),
  .key_hit   (key_hit),
  .masked    (masked)
);

// File: tb/test_gfx_pixel_expander.sv
module test_gfx_pixel_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pixel = '0;
  logic [3:0]  in_fmt = '0;
  logic        in_stencil = 1'b1;
  logic        stencil_en = 1'b0;
  logic [7:0]  global_alpha = 8'hFF;
  logic [1:0]  alpha_mode = 2'd1;
  logic        clut_alpha_sel = 1'b0;
  logic        key_en = 1'b0;
  logic [23:0] key_rgb = '0;
  logic        clut_we = 1'b0;
  logic [7:0]  clut_waddr = '0;
  logic [31:0] clut_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_argb;
  logic [7:0]  out_alpha;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [31:0] mdl [256];

  always #5 clk = ~clk;

  gfx_pixel_expander i_gfx_pixel_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_fmt(in_fmt), .in_stencil(in_stencil),
    .stencil_en(stencil_en), .global_alpha(global_alpha), .alpha_mode(alpha_mode),
    .clut_alpha_sel(clut_alpha_sel), .key_en(key_en), .key_rgb(key_rgb),
    .clut_we(clut_we), .clut_waddr(clut_waddr), .clut_wdata(clut_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_argb(out_argb),
    .out_alpha(out_alpha)
  );

  function automatic int up5(input int v); return (v << 3) | (v >> 2); endfunction
  function automatic int up6(input int v); return (v << 2) | (v >> 4); endfunction

  function automatic logic [31:0] model_argb(input logic [31:0] p, input logic [3:0] f);
    int a, r, g, b, ix;
    logic [31:0] e;
    case (f)
      4'd1: return {8'hFF, p[23:0]};
      4'd2: begin
        a = p[15] ? 255 : 0; r = up5(int'(p[14:10])); g = up5(int'(p[9:5])); b = up5(int'(p[4:0]));
        return {a[7:0], r[7:0], g[7:0], b[7:0]};
      end
      4'd3: begin
        r = up5(int'(p[15:11])); g = up6(int'(p[10:5])); b = up5(int'(p[4:0]));
        return {8'hFF, r[7:0], g[7:0], b[7:0]};
      end
      4'd4: begin
        a = int'(p[15:12]) * 17; r = int'(p[11:8]) * 17; g = int'(p[7:4]) * 17; b = int'(p[3:0]) * 17;
        return {a[7:0], r[7:0], g[7:0], b[7:0]};
      end
      4'd5, 4'd6, 4'd7, 4'd8: begin
        ix = (f == 4'd5) ? (p & 1) : (f == 4'd6) ? (p & 3) : (f == 4'd7) ? (p & 15) : (p & 255);
        e = mdl[ix];
        return {clut_alpha_sel ? e[31:24] : 8'hFF, e[23:0]};
      end
      default: return p;
    endcase
  endfunction

  function automatic logic [7:0] model_alpha(input logic [31:0] c, input logic s);
    int prod;
    if (stencil_en && !s) return 8'h00;
    if (key_en && c[23:0] == key_rgb) return 8'h00;
    if (alpha_mode == 2'd0) return global_alpha;
    if (alpha_mode == 2'd1) return c[31:24];
    prod = (int'(c[31:24]) * int'(global_alpha) + 127) / 255;
    return prod[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [3:0] f, input logic s, input string req);
    logic [31:0] ec;
    logic [7:0]  ea;
    @(negedge clk);
    in_pixel = p; in_fmt = f; in_stencil = s; in_valid = 1'b1;
    ec = model_argb(p, f);
    ea = model_alpha(ec, s);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " argb"}, out_argb, ec);
    check({req, " alpha"}, {24'd0, out_alpha}, {24'd0, ea});
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ec, pa, pb;
    logic [7:0]  ea;
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    clut_alpha_sel = 1'b1;
    apply(32'h0000_0037, 4'd8, 1'b1, "R1 clut zero");
    // fill table
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      clut_we = 1'b1; clut_waddr = i[7:0]; clut_wdata = $urandom;
      mdl[i] = clut_wdata;
    end
    @(negedge clk); clut_we = 1'b0;
    // directed
    alpha_mode = 2'd1; clut_alpha_sel = 1'b1;
    apply(32'h8012_3456, 4'd0, 1'b1, "R2 argb8888");
    apply(32'h0012_3456, 4'd1, 1'b0, "R2 rgb888");
    apply(32'h1234_FFFF, 4'd3, 1'b1, "R3 rgb565 full");
    apply(32'h0000_7C1F, 4'd2, 1'b1, "R3 argb1555");
    apply(32'h0000_A5C3, 4'd4, 1'b1, "R3 argb4444");
    apply(32'hFFFF_FFFE, 4'd5, 1'b1, "R4 idx1 low bit");
    apply(32'hFFFF_FFF6, 4'd7, 1'b1, "R4 idx4");
    clut_alpha_sel = 1'b0;
    apply(32'h0000_00C9, 4'd8, 1'b1, "R5 idx8 opaque");
    apply(32'hABCD_1234, 4'd12, 1'b1, "R11 reserved code");
    alpha_mode = 2'd2; global_alpha = 8'h80;
    apply(32'h8011_2233, 4'd0, 1'b1, "R6 product");
    alpha_mode = 2'd0; global_alpha = 8'h5A;
    apply(32'h1011_2233, 4'd0, 1'b1, "R6 global");
    key_en = 1'b1; key_rgb = 24'hFFFFFF; alpha_mode = 2'd1;
    apply(32'h0000_FFFF, 4'd3, 1'b1, "R7 key hit");
    apply(32'h0000_FFFE, 4'd3, 1'b1, "R7 key miss");
    key_en = 1'b0; stencil_en = 1'b1;
    apply(32'hFF00_00FF, 4'd0, 1'b0, "R8 masked");
    stencil_en = 1'b0;
    apply(32'hFF00_00FF, 4'd0, 1'b0, "R8 stencil off");
    // R10: same-edge write and read
    clut_alpha_sel = 1'b1;
    @(negedge clk);
    clut_we = 1'b1; clut_waddr = 8'd5; clut_wdata = 32'h7755_AA33;
    in_pixel = 32'h5; in_fmt = 4'd8; in_stencil = 1'b1; in_valid = 1'b1;
    ec = model_argb(32'h5, 4'd8); ea = model_alpha(ec, 1'b1);
    @(negedge clk);
    clut_we = 1'b0; in_valid = 1'b0; mdl[5] = 32'h7755_AA33;
    check("R10 old entry", out_argb, ec);
    check("R10 old alpha", {24'd0, out_alpha}, {24'd0, ea});
    apply(32'h5, 4'd8, 1'b1, "R10 new entry");
    // R9: stall
    alpha_mode = 2'd1;
    pa = 32'h4433_2211; pb = 32'h99AA_BBCC;
    @(negedge clk);
    out_ready = 1'b0; in_pixel = pa; in_fmt = 4'd0; in_valid = 1'b1;
    @(negedge clk);
    in_pixel = pb;
    check("R9 ready low", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R9 held argb", out_argb, pa);
    check("R9 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next pixel", out_argb, pb);
    @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);
    // random
    for (int k = 0; k < 600; k++) begin
      logic [31:0] p;
      logic [3:0]  f;
      p = $urandom; f = 4'($urandom_range(0, 15));
      alpha_mode = 2'($urandom); global_alpha = 8'($urandom);
      clut_alpha_sel = 1'($urandom); stencil_en = 1'($urandom);
      key_en = 1'($urandom);
      ec = model_argb(p, f);
      key_rgb = ($urandom_range(0, 3) == 0) ? ec[23:0] : 24'($urandom);
      apply(p, f, 1'($urandom), "R6 R7 R8 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule